// File: doc/BRIEF.md
# ADC Result Alignment Formatter

This block turns a raw converter sample into the 16-bit value that a data register presents. The conversion width is chosen per sample as 12, 10, 8 or 6 bits, and the value can be packed against the low end of the word (right-aligned) or against the high end (left-aligned). Left alignment lets software treat the word as a fraction of full scale without shifting it first.

Samples are marked either regular or injected. A regular sample is placed as an unsigned number, and every bit not covered by data is zero. An injected sample first has a programmable offset subtracted from it. The signed difference is then placed with its sign copied into the upper bits. At 6-bit resolution, left alignment uses a placement of its own inside the low byte.

All configuration is sampled in the same cycle as the sample strobe. The result appears one clock later in a register, together with a one-cycle valid pulse.

Top module: `adc_align_fmt`

## Requirements
- R1: The `res_sel_i` encoding is 0 for 12 bits, 1 for 10 bits, 2 for 8 bits and 3 for 6 bits (N = 12 - 2*sel). Only bits N-1:0 of the sample and of the offset take part; their higher bits have no effect on the result.
- R2: For a regular sample with `align_left_i`=0, `dr_o` equals the N-bit sample, zero-extended to 16 bits.
- R3: For a regular sample with `align_left_i`=1 and N of 8 or more, `dr_o` equals the sample shifted left by 16-N. The sample MSB sits at bit 15 and the low bits are zero.
- R4: For a regular sample with `align_left_i`=1 and N=6, `dr_o` equals the sample shifted left by 2. Bits 15:8 and 1:0 are zero.
- R5: For an injected sample (`inj_i`=1), the difference sample minus offset is formed as an N+1-bit two's-complement value. With `align_left_i`=0, `dr_o` holds that difference sign-extended to 16 bits.
- R6: For an injected sample with `align_left_i`=1 and N of 8 or more, `dr_o` equals the N+1-bit difference shifted left by 15-N. Its sign bit sits at bit 15 and the low bits are zero.
- R7: For an injected sample with `align_left_i`=1 and N=6, `dr_o` equals the difference sign-extended to 16 bits and shifted left by 1. Bits 15:8 hold sign copies and bit 0 is zero.
- R8: `dr_valid_o` is high in exactly the cycle after a cycle with `smp_valid_i` high. The result is computed from the configuration present in that strobe cycle.
- R9: When `smp_valid_i` is low, `dr_o` keeps its value. The configuration inputs then have no effect on it.
- R10: While reset is asserted, and until the first strobe after reset, `dr_o` and `dr_valid_o` read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Raw converter sample, data in low N bits |
| res_sel_i | input | 2 | Resolution select (0:12, 1:10, 2:8, 3:6 bits) |
| align_left_i | input | 1 | 1 = left alignment, 0 = right alignment |
| inj_i | input | 1 | 1 = injected sample (offset subtracted, signed) |
| offset_i | input | 12 | Offset for injected samples, low N bits used |
| dr_o | output | 16 | Formatted data register value |
| dr_valid_o | output | 1 | One-cycle pulse with a new result |

## Verification
The assertions assume that `smp_valid_i` stays low while the internal synchronized reset is still asserted. The bench keeps the strobe low for several cycles after releasing `rst_n` to satisfy this. The assertions also assume that the configuration inputs may change every cycle, so they read the configuration through `$past` of the strobe cycle. The stimulus follows this: it changes the sample, offset, resolution, alignment and injected flag on each idle cycle as well as on each strobe cycle. It also drives sample and offset bits above N with junk, which exercises the masking.

// File: rtl/adc_align_pkg.sv
package adc_align_pkg;
  localparam int unsigned DR_W    = 16;
  localparam int unsigned MAX_RES = 12;
  localparam int unsigned SH_W    = $clog2(DR_W + 1);

  typedef enum logic [1:0] {
    RES_12 = 2'd0,
    RES_10 = 2'd1,
    RES_8  = 2'd2,
    RES_6  = 2'd3
  } res_sel_e;
endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/adc_res_decode.sv
module adc_res_decode
  import adc_align_pkg::*;
#(
  parameter int unsigned RES_W = MAX_RES
) (
  input  logic [1:0]       res_sel,
  output logic [SH_W-1:0]  res_bits,
  output logic [RES_W-1:0] res_mask,
  output logic             is_six
);
  always_comb begin
    unique case (res_sel_e'(res_sel))
      RES_12: res_bits = SH_W'(12);
      RES_10: res_bits = SH_W'(10);
      RES_8:  res_bits = SH_W'(8);
      default: res_bits = SH_W'(6);
    endcase
    is_six = (res_sel_e'(res_sel) == RES_6);
  end

  for (genvar b = 0; b < RES_W; b++) begin : g_mask
    assign res_mask[b] = (SH_W'(b) < res_bits);
  end
endmodule

// File: rtl/adc_offset_sub.sv
module adc_offset_sub
  import adc_align_pkg::*;
#(
  parameter int unsigned RES_W = MAX_RES,
  parameter int unsigned OUT_W = DR_W
) (
  input  logic [RES_W-1:0] sample,
  input  logic [RES_W-1:0] offset,
  input  logic [RES_W-1:0] mask,
  input  logic             inj,
  output logic [OUT_W-1:0] value_ext
);
  logic [RES_W-1:0]        raw_m;
  logic [RES_W-1:0]        off_m;
  logic signed [RES_W:0]   diff;
  logic [RES_W:0]          diff_u;
  logic [RES_W:0]          sign_sel;
  logic                    sgn;

  always_comb begin
    raw_m  = sample & mask;
    off_m  = offset & mask;
    diff_u = {1'b0, raw_m} - {1'b0, off_m};
    diff   = $signed(diff_u);
    // sign of the N+1-bit difference: bit N, picked by the mask edge
    sign_sel = {1'b1, ~mask} & {1'b0, mask, 1'b1};
    sgn      = |(diff_u & sign_sel);
    value_ext = OUT_W'(raw_m);
    if (inj) begin
      value_ext = OUT_W'(diff_u & {1'b0, mask});
      for (int b = 0; b < int'(OUT_W); b++) begin
        if (b < RES_W && mask[b]) value_ext[b] = diff_u[b];
        else if (!(b < RES_W && mask[b])) value_ext[b] = sgn;
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^diff;
endmodule

// File: rtl/adc_align_place.sv
module adc_align_place
  import adc_align_pkg::*;
#(
  parameter int unsigned OUT_W = DR_W
) (
  input  logic [OUT_W-1:0] value_ext,
  input  logic [SH_W-1:0]  res_bits,
  input  logic             is_six,
  input  logic             inj,
  input  logic             align_left,
  output logic [OUT_W-1:0] placed
);
  localparam logic [SH_W-1:0] TOP_REG = SH_W'(OUT_W);
  localparam logic [SH_W-1:0] TOP_SIX = SH_W'(8);

  logic [SH_W-1:0] base;
  logic [SH_W-1:0] shamt;

  always_comb begin
    base   = is_six ? TOP_SIX : TOP_REG;
    if (inj) base = base - SH_W'(1);
    shamt  = align_left ? (base - res_bits) : '0;
    placed = value_ext << shamt;
  end
endmodule

// File: rtl/adc_align_fmt.sv
module adc_align_fmt
  import adc_align_pkg::*;
#(
  parameter int unsigned RES_W = MAX_RES,
  parameter int unsigned OUT_W = DR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid_i,
  input  logic [RES_W-1:0] smp_data_i,
  input  logic [1:0]       res_sel_i,
  input  logic             align_left_i,
  input  logic             inj_i,
  input  logic [RES_W-1:0] offset_i,
  output logic [OUT_W-1:0] dr_o,
  output logic             dr_valid_o
);
  logic             rst_sync_n;
  logic [SH_W-1:0]  res_bits;
  logic [RES_W-1:0] res_mask;
  logic             is_six;
  logic [OUT_W-1:0] value_ext;
  logic [OUT_W-1:0] placed;
  logic [OUT_W-1:0] dr_q, dr_d;
  logic             vld_q, vld_d;

  adc_rst_sync #(.STAGES(2)) rst_i (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  adc_res_decode #(.RES_W(RES_W)) dec_i (
    .res_sel(res_sel_i), .res_bits(res_bits), .res_mask(res_mask), .is_six(is_six)
  );

  adc_offset_sub #(.RES_W(RES_W), .OUT_W(OUT_W)) sub_i (
    .sample(smp_data_i), .offset(offset_i), .mask(res_mask),
    .inj(inj_i), .value_ext(value_ext)
  );

  adc_align_place #(.OUT_W(OUT_W)) plc_i (
    .value_ext(value_ext), .res_bits(res_bits), .is_six(is_six),
    .inj(inj_i), .align_left(align_left_i), .placed(placed)
  );

  always_comb begin
    dr_d  = smp_valid_i ? placed : dr_q;
    vld_d = smp_valid_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dr_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      dr_q  <= dr_d;
      vld_q <= vld_d;
    end
  end

  assign dr_o       = dr_q;
  assign dr_valid_o = vld_q;
endmodule

// File: rtl/adc_align_fmt_chk.sv
module adc_align_fmt_chk #(
  parameter int unsigned RES_W = 12,
  parameter int unsigned OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             smp_valid_i,
  input logic [1:0]       res_sel_i,
  input logic             align_left_i,
  input logic             inj_i,
  input logic [OUT_W-1:0] dr_o,
  input logic             dr_valid_o
);
  function automatic int unsigned nbits(input logic [1:0] s);
    return 12 - 2 * int'(s);
  endfunction

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid_i |=> dr_valid_o);
  a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> !dr_valid_o);
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid_i |=> $stable(dr_o));
  a_r2_right_zero_top: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !inj_i && !align_left_i) |=>
      ((dr_o >> nbits($past(res_sel_i))) == '0));
  a_r3_left_msb_top: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !inj_i && align_left_i && res_sel_i != 2'd3) |=>
      ((dr_o << nbits($past(res_sel_i))) == '0));
  a_r4_six_left_window: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && !inj_i && align_left_i && res_sel_i == 2'd3) |=>
      (dr_o[15:8] == 8'h00 && dr_o[1:0] == 2'b00));
  a_r5_sign_copies: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && inj_i && !align_left_i) |=>
      (($signed(dr_o) >>> nbits($past(res_sel_i))) == 0 ||
       ($signed(dr_o) >>> nbits($past(res_sel_i))) == -1));
  a_r7_six_inj_left: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid_i && inj_i && align_left_i && res_sel_i == 2'd3) |=>
      (dr_o[0] == 1'b0 && (dr_o[15:7] == 9'h000 || dr_o[15:7] == 9'h1FF)));
endmodule

bind adc_align_fmt adc_align_fmt_chk #(.RES_W(RES_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rst_n(rst_sync_n), .smp_valid_i(smp_valid_i),
  .res_sel_i(res_sel_i), .align_left_i(align_left_i), .inj_i(inj_i),
  .dr_o(dr_o), .dr_valid_o(dr_valid_o)
);

// File: tb/adc_align_fmt_tb_top.sv
`timescale 1ns/1ps
module adc_align_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_data_i = '0;
  logic [1:0]  res_sel_i = '0;
  logic        align_left_i = 1'b0;
  logic        inj_i = 1'b0;
  logic [11:0] offset_i = '0;
  logic [15:0] dr_o;
  logic        dr_valid_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic [15:0] exp_dr = '0;
  logic        exp_vld = 1'b0;
  string       exp_tag = "R10";
  bit          run_cmp = 1'b0;

  always #2.5 clk = ~clk;

  adc_align_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid_i(smp_valid_i), .smp_data_i(smp_data_i),
    .res_sel_i(res_sel_i), .align_left_i(align_left_i), .inj_i(inj_i),
    .offset_i(offset_i), .dr_o(dr_o), .dr_valid_o(dr_valid_o)
  );

  function automatic logic [15:0] model(input int d, input int o, input int sel,
                                        input bit left, input bit inj);
    int n = 12 - 2 * sel;
    int raw = d % (1 << n);
    int off = o % (1 << n);
    int val = inj ? raw - off : raw;
    int sh = 0;
    if (left) begin
      if (n == 6) sh = inj ? 1 : 2;
      else        sh = inj ? 15 - n : 16 - n;
    end
    val = val * (1 << sh);
    return val[15:0];
  endfunction

  function automatic string tag_of(input int d, input int o, input int sel,
                                   input bit left, input bit inj);
    string t;
    int n = 12 - 2 * sel;
    if (!inj && !left)             t = "R2";
    else if (!inj && n != 6)       t = "R3";
    else if (!inj)                 t = "R4";
    else if (!left)                t = "R5";
    else if (n != 6)               t = "R6";
    else                           t = "R7";
    if ((d >> n) != 0 || (o >> n) != 0) t = {"R1/", t};
    return t;
  endfunction

  // reference model: updates on the same edge the DUT samples
  always @(posedge clk) begin
    if (!rst_n) begin
      exp_dr = '0; exp_vld = 1'b0; exp_tag = "R10";
    end else begin
      exp_vld = smp_valid_i;
      if (smp_valid_i) begin
        exp_dr  = model(int'(smp_data_i), int'(offset_i), int'(res_sel_i), align_left_i, inj_i);
        exp_tag = tag_of(int'(smp_data_i), int'(offset_i), int'(res_sel_i), align_left_i, inj_i);
      end else begin
        exp_tag = "R9";
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (run_cmp) begin
      check({exp_tag, " dr"}, 32'(dr_o), 32'(exp_dr));
      check("R8 valid", 32'(dr_valid_o), 32'(exp_vld));
    end
  end

  task automatic drive(input bit v, input int d, input int o, input int sel,
                       input bit left, input bit inj);
    smp_valid_i = v; smp_data_i = 12'(d); offset_i = 12'(o);
    res_sel_i = 2'(sel); align_left_i = left; inj_i = inj;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset dr", 32'(dr_o), 32'h0);
    check("R10 reset valid", 32'(dr_valid_o), 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 post-reset dr", 32'(dr_o), 32'h0);
    run_cmp = 1'b1;
    // directed corners at every resolution
    for (int sel = 0; sel < 4; sel++) begin
      int n = 12 - 2 * sel;
      int full = (1 << n) - 1;
      drive(1, full, 0, sel, 0, 0);
      drive(1, full, 0, sel, 1, 0);
      drive(1, 1, 0, sel, 1, 0);
      drive(1, 0, full, sel, 0, 1);
      drive(1, 0, full, sel, 1, 1);
      drive(1, full, 0, sel, 1, 1);
      drive(1, full, full, sel, 1, 1);
      drive(1, 12'hFFF, 12'hFFF, sel, 0, 1);
      drive(1, 12'hA5A, 12'h5A5, sel, 1, 0);
      drive(0, 12'h123, 12'h456, (sel + 1) % 4, 1, 1);
      drive(0, 12'h0, 12'h0, sel, 0, 0);
    end
    // randomized mix, strobe about 3/4 of cycles
    for (int i = 0; i < 3000; i++) begin
      drive(($urandom % 4) != 0, int'($urandom % 4096), int'($urandom % 4096),
            int'($urandom % 4), 1'($urandom), 1'($urandom));
    end
    drive(0, 0, 0, 0, 0, 0);
    run_cmp = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule